// File: doc/BRIEF.md
# Line-Based Branch Target Predictor

This block predicts where instruction fetch goes next. It is consulted once per fetch line. The fetch address is split into a line tag, a set index and a byte offset within the line. Every way of the indexed set whose tag matches contributes one known branch, and each such branch carries its own offset inside the line.

Branches that sit before the fetch offset are ignored. Among the branches that remain, the one at the lowest offset that is predicted taken becomes the prediction, and the block reports its target, kind and offset. If no such branch exists, fetch continues at the next sequential line.

Conditional branches are predicted by a table of 2-bit saturating counters kept per set. Each entry's local history selects the counter it uses. History is shifted with the predicted direction at lookup time and corrected by the resolve port once the real outcome is known. A resolve that finds no entry allocates one.

Top module: `btb_line_pred`

## Requirements
- R1: After reset `pred_valid` and `pred_taken` are 0 and every entry is invalid, so any lookup misses.
- R2: A lookup presented with `fetch_valid` produces its result exactly one clock later with `pred_valid` high for one cycle; `pred_valid` is low in cycles that follow no lookup.
- R3: Address fields are offset = bits [3:0], set = bits [10:4] and tag = bits [31:11]; an entry counts only if its set and tag both equal those of the fetch address.
- R4: A matching branch whose offset is below the fetch offset is discarded; a branch at exactly the fetch offset qualifies.
- R5: Among the qualifying branches predicted taken, the one with the lowest offset is reported: `pred_taken`=1, with its target, kind and offset.
- R6: Kind encoding is 2'b00 conditional, 2'b01 return, 2'b10 call, 2'b11 unconditional; the last three are always predicted taken, whatever the counter value.
- R7: A conditional branch is predicted taken when bit 1 of its set's counter selected by the low 4 history bits is 1; counters reset to 2'b01 and saturate at 2'b00 and 2'b11.
- R8: On a miss `pred_taken`=0, `pred_target` is the fetch line address plus 16 with its low 4 bits zero, and `pred_kind` and `pred_offset` are 0.
- R9: A lookup shifts its predicted direction into the 5-bit history of every qualifying conditional branch up to and including the chosen one. A resolve trains the counter indexed by history bits [4:1] and overwrites history bit 0 with the actual outcome.
- R10: A resolve that hits an entry (same set, tag and offset) overwrites the entry's target and kind.
- R11: A resolve that misses allocates the lowest-numbered invalid way of the set, or else the way named by the set's 2-bit round-robin pointer. The pointer advances on every allocation. The new entry's history is cleared and the set's counter 0 is written to 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Lookup request for this cycle |
| fetch_addr | input | 32 | Fetch address (tag, set, offset) |
| upd_valid | input | 1 | Resolved branch update |
| upd_addr | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | 32 | Resolved target address |
| upd_kind | input | 2 | Branch kind of the resolved branch |
| pred_valid | output | 1 | Prediction result present |
| pred_taken | output | 1 | A taken branch was found in the line |
| pred_target | output | 32 | Next fetch address |
| pred_kind | output | 2 | Kind of the chosen branch |
| pred_offset | output | 4 | Offset of the chosen branch within the line |

## Verification
A corrupted tag, offset or valid bit shows up on the very next lookup of that line: the reported branch moves to the wrong offset, or a hit turns into a sequential-line miss. Counter and history faults stay hidden until a conditional branch is looked up. The directed sequences train a counter through saturation and then read it back. They also step history so that a different counter index is selected, which exposes an index or saturation error within two or three resolves. Replacement faults appear when a fifth tag enters a full set and the wrong earlier line stops hitting.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        BR_COND = 2'b00,
        BR_RET  = 2'b01,
        BR_CALL = 2'b10,
        BR_JMP  = 2'b11
    } br_kind_e;

    localparam logic [1:0] CTR_WEAK_NT = 2'b01;
    localparam logic [1:0] CTR_WEAK_TK = 2'b10;

    // saturating two-bit step toward taken (up=1) or not taken
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        logic [1:0] r;
        if (up) r = (c == 2'b11) ? 2'b11 : c + 2'b01;
        else    r = (c == 2'b00) ? 2'b00 : c - 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/btb_pick.sv
module btb_pick #(
    parameter int WAYS  = 4,
    parameter int OFF_W = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WAYS-1:0]              cand,
    input  logic [WAYS-1:0][OFF_W-1:0]   offs,
    input  logic [WAYS-1:0]              tkn,
    input  logic [OFF_W-1:0]             start_off,
    output logic                         pick_vld,
    output logic [WAY_W-1:0]             pick_way,
    output logic [OFF_W-1:0]             pick_off,
    output logic [WAYS-1:0]              seen
);

    always_comb begin
        pick_vld = 1'b0;
        pick_way = '0;
        pick_off = '1;
        for (int w = 0; w < WAYS; w++) begin
            if (cand[w] && tkn[w] && (offs[w] >= start_off) &&
                (!pick_vld || offs[w] < pick_off)) begin
                pick_vld = 1'b1;
                pick_way = WAY_W'(w);
                pick_off = offs[w];
            end
        end
        for (int w = 0; w < WAYS; w++) begin
            seen[w] = cand[w] && (offs[w] >= start_off) &&
                      (!pick_vld || offs[w] <= pick_off);
        end
        if (!pick_vld) pick_off = '0;
    end

    // R4
    pick_not_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> (pick_off >= start_off));

    generate
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_order
            // R5
            lowest_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pick_vld && cand[gw] && tkn[gw] && (offs[gw] >= start_off))
                |-> (offs[gw] >= pick_off));
        end
    endgenerate

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAYS-1:0]   way_vld,
    input  logic [WAY_W-1:0]  rr_ptr,
    output logic [WAY_W-1:0]  victim
);

    always_comb begin
        logic found;
        found  = 1'b0;
        victim = rr_ptr;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !way_vld[w]) begin
                found  = 1'b1;
                victim = WAY_W'(w);
            end
        end
    end

    // R11
    free_way_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&way_vld)) |-> !way_vld[victim]);

endmodule

// File: rtl/btb_line_pred.sv
module btb_line_pred
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int SET_W  = 7,
    parameter int WAYS   = 4,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic [1:0]        upd_kind,
    output logic              pred_valid,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic [1:0]        pred_kind,
    output logic [OFF_W-1:0]  pred_offset
);

    localparam int SETS   = 1 << SET_W;
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int HENT_W = HIST_W + 1;
    localparam int PAT_N  = 1 << HIST_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              vld;
        logic              tkn;
        logic [ADDR_W-1:0] tgt;
        logic [1:0]        kind;
        logic [OFF_W-1:0]  off;
    } pred_t;

    // entry storage
    logic              vld_q  [SETS][WAYS];
    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [OFF_W-1:0]  off_q  [SETS][WAYS];
    logic [1:0]        kind_q [SETS][WAYS];
    logic [ADDR_W-1:0] tgt_q  [SETS][WAYS];
    logic [HENT_W-1:0] hist_q [SETS][WAYS];
    logic [1:0]        ctr_q  [SETS][PAT_N];
    logic [WAY_W-1:0]  rr_q   [SETS];

    pred_t pred_d, pred_q;

    // fetch address fields
    logic [OFF_W-1:0] f_off;
    logic [SET_W-1:0] f_set;
    logic [TAG_W-1:0] f_tag;
    assign f_off = fetch_addr[OFF_W-1:0];
    assign f_set = fetch_addr[OFF_W+SET_W-1:OFF_W];
    assign f_tag = fetch_addr[ADDR_W-1:OFF_W+SET_W];

    // update address fields
    logic [OFF_W-1:0] u_off;
    logic [SET_W-1:0] u_set;
    logic [TAG_W-1:0] u_tag;
    assign u_off = upd_addr[OFF_W-1:0];
    assign u_set = upd_addr[OFF_W+SET_W-1:OFF_W];
    assign u_tag = upd_addr[ADDR_W-1:OFF_W+SET_W];

    logic [WAYS-1:0]             f_match, f_tkn, u_match, u_set_vld;
    logic [WAYS-1:0][OFF_W-1:0]  f_offs;
    logic [WAYS-1:0][HENT_W-1:0] f_hist;

    generate
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
            logic [HIST_W-1:0] hlo;
            assign hlo          = hist_q[f_set][gw][HIST_W-1:0];
            assign f_hist[gw]   = hist_q[f_set][gw];
            assign f_offs[gw]   = off_q[f_set][gw];
            assign f_match[gw]  = vld_q[f_set][gw] && (tag_q[f_set][gw] == f_tag);
            assign f_tkn[gw]    = (kind_q[f_set][gw] != BR_COND) || ctr_q[f_set][hlo][1];
            assign u_set_vld[gw] = vld_q[u_set][gw];
            assign u_match[gw]  = vld_q[u_set][gw] && (tag_q[u_set][gw] == u_tag) &&
                                  (off_q[u_set][gw] == u_off);
        end
    endgenerate

    logic             pick_vld;
    logic [WAY_W-1:0] pick_way;
    logic [OFF_W-1:0] pick_off;
    logic [WAYS-1:0]  seen;

    btb_pick #(.WAYS(WAYS), .OFF_W(OFF_W)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .cand      (f_match),
        .offs      (f_offs),
        .tkn       (f_tkn),
        .start_off (f_off),
        .pick_vld  (pick_vld),
        .pick_way  (pick_way),
        .pick_off  (pick_off),
        .seen      (seen)
    );

    logic [WAY_W-1:0] victim;

    btb_victim #(.WAYS(WAYS)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .way_vld (u_set_vld),
        .rr_ptr  (rr_q[u_set]),
        .victim  (victim)
    );

    // next-state values for prediction and storage writes
    logic [WAYS-1:0]             spec_we_d;
    logic [WAYS-1:0][HENT_W-1:0] spec_hist_d;
    logic                        hit_we_d, train_d, alloc_we_d;
    logic [WAY_W-1:0]            u_way_d;
    logic [HIST_W-1:0]           ctr_idx_d;
    logic [1:0]                  ctr_new_d;
    logic [LINE_W-1:0]           next_line;

    always_comb begin
        next_line = fetch_addr[ADDR_W-1:OFF_W] + LINE_W'(1);
        pred_d    = '0;
        if (fetch_valid) begin
            pred_d.vld = 1'b1;
            if (pick_vld) begin
                pred_d.tkn  = 1'b1;
                pred_d.tgt  = tgt_q[f_set][pick_way];
                pred_d.kind = kind_q[f_set][pick_way];
                pred_d.off  = pick_off;
            end else begin
                pred_d.tgt = {next_line, OFF_W'(0)};
            end
        end

        for (int w = 0; w < WAYS; w++) begin
            spec_we_d[w]   = fetch_valid && seen[w] && (kind_q[f_set][w] == BR_COND);
            spec_hist_d[w] = {f_hist[w][HIST_W-1:0], f_tkn[w]};
        end

        u_way_d = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (u_match[w]) u_way_d = WAY_W'(w);
        end
        hit_we_d   = upd_valid && (|u_match);
        alloc_we_d = upd_valid && !(|u_match);
        train_d    = hit_we_d && (upd_kind == BR_COND);
        ctr_idx_d  = hist_q[u_set][u_way_d][HENT_W-1:1];
        ctr_new_d  = ctr_step(ctr_q[u_set][ctr_idx_d], upd_taken);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                rr_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    vld_q[s][w]  <= 1'b0;
                    hist_q[s][w] <= '0;
                end
                for (int p = 0; p < PAT_N; p++) begin
                    ctr_q[s][p] <= CTR_WEAK_NT;
                end
            end
        end else begin
            pred_q <= pred_d;
            for (int w = 0; w < WAYS; w++) begin
                if (spec_we_d[w]) hist_q[f_set][w] <= spec_hist_d[w];
            end
            if (hit_we_d) begin
                tgt_q[u_set][u_way_d]  <= upd_target;
                kind_q[u_set][u_way_d] <= upd_kind;
                if (train_d) begin
                    ctr_q[u_set][ctr_idx_d]   <= ctr_new_d;
                    hist_q[u_set][u_way_d][0] <= upd_taken;
                end
            end
            if (alloc_we_d) begin
                vld_q[u_set][victim]  <= 1'b1;
                tag_q[u_set][victim]  <= u_tag;
                off_q[u_set][victim]  <= u_off;
                kind_q[u_set][victim] <= upd_kind;
                tgt_q[u_set][victim]  <= upd_target;
                hist_q[u_set][victim] <= '0;
                ctr_q[u_set][0]       <= CTR_WEAK_TK;
                rr_q[u_set]           <= rr_q[u_set] + WAY_W'(1);
            end
        end
    end

    assign pred_valid  = pred_q.vld;
    assign pred_taken  = pred_q.tkn;
    assign pred_target = pred_q.tgt;
    assign pred_kind   = pred_q.kind;
    assign pred_offset = pred_q.off;

    // R2
    result_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> $past(fetch_valid));

    // R8
    miss_is_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_taken) |->
        ((pred_target[OFF_W-1:0] == '0) && (pred_kind == 2'b00) && (pred_offset == '0)));

    // R1
    idle_no_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> !pred_taken);

endmodule

// File: tb/btb_line_pred_test.sv
module btb_line_pred_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_addr = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;
    logic [1:0]  upd_kind = '0;
    logic        pred_valid, pred_taken;
    logic [31:0] pred_target;
    logic [1:0]  pred_kind;
    logic [3:0]  pred_offset;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    btb_line_pred uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
        .upd_target(upd_target), .upd_kind(upd_kind),
        .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target),
        .pred_kind(pred_kind), .pred_offset(pred_offset)
    );

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return 32'((tag << 11) | (set << 4) | off);
    endfunction

    function automatic logic [31:0] next_line(input logic [31:0] a);
        return {a[31:4] + 28'd1, 4'd0};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; result visible at the next falling edge
    task automatic lookup(input logic [31:0] a);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic resolve(input logic [31:0] a, input logic tk,
                           input logic [31:0] tg, input logic [1:0] k);
        upd_valid  = 1'b1;
        upd_addr   = a;
        upd_taken  = tk;
        upd_target = tg;
        upd_kind   = k;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] tg,
                              input logic [1:0] k, input logic [3:0] off);
        check(req, "valid",  32'(pred_valid), 32'd1);
        check(req, "taken",  32'(pred_taken), 32'd1);
        check(req, "target", pred_target, tg);
        check(req, "kind",   32'(pred_kind), 32'(k));
        check(req, "offset", 32'(pred_offset), 32'(off));
    endtask

    task automatic expect_miss(input string req, input logic [31:0] a);
        check(req, "valid",  32'(pred_valid), 32'd1);
        check(req, "taken",  32'(pred_taken), 32'd0);
        check(req, "target", pred_target, next_line(a));
        check(req, "kind",   32'(pred_kind), 32'd0);
        check(req, "offset", 32'(pred_offset), 32'd0);
    endtask

    task automatic t_reset;
        check("R1", "valid after reset", 32'(pred_valid), 32'd0);
        check("R1", "taken after reset", 32'(pred_taken), 32'd0);
        lookup(mk(3, 5, 0));
        expect_miss("R1", mk(3, 5, 0));
        lookup(mk(3, 5, 9));
        expect_miss("R8", mk(3, 5, 9));
    endtask

    task automatic t_latency;
        lookup(mk(7, 1, 2));
        check("R2", "valid one cycle later", 32'(pred_valid), 32'd1);
        @(negedge clk);
        check("R2", "valid drops without request", 32'(pred_valid), 32'd0);
    endtask

    task automatic t_order;
        resolve(mk(3, 5, 6), 1'b1, 32'h1000, 2'b11);
        resolve(mk(3, 5, 10), 1'b1, 32'h2000, 2'b10);
        lookup(mk(3, 5, 0));
        expect_hit("R5", 32'h1000, 2'b11, 4'd6);
        lookup(mk(3, 5, 6));
        expect_hit("R4", 32'h1000, 2'b11, 4'd6);
        lookup(mk(3, 5, 7));
        expect_hit("R4", 32'h2000, 2'b10, 4'd10);
        lookup(mk(3, 5, 11));
        expect_miss("R8", mk(3, 5, 11));
    endtask

    task automatic t_tag;
        lookup(mk(9, 5, 0));
        expect_miss("R3", mk(9, 5, 0));
    endtask

    task automatic t_cond_history;
        // allocation: history 0, counter 0 of set 5 becomes weakly taken
        resolve(mk(3, 5, 2), 1'b1, 32'h3000, 2'b00);
        lookup(mk(3, 5, 0));
        expect_hit("R7", 32'h3000, 2'b00, 4'd2);
        // history now 00001; resolve trains index 0 down to 01
        resolve(mk(3, 5, 2), 1'b0, 32'h3000, 2'b00);
        lookup(mk(3, 5, 0));
        expect_hit("R9", 32'h1000, 2'b11, 4'd6);
        // index 0: 01 -> 00 -> 01 -> 10, history bit0 ends at 1
        resolve(mk(3, 5, 2), 1'b0, 32'h3000, 2'b00);
        resolve(mk(3, 5, 2), 1'b1, 32'h3000, 2'b00);
        resolve(mk(3, 5, 2), 1'b1, 32'h3000, 2'b00);
        // history low bits 0001 select counter 1, still 01
        lookup(mk(3, 5, 0));
        expect_hit("R9", 32'h1000, 2'b11, 4'd6);
    endtask

    task automatic t_retarget;
        resolve(mk(3, 5, 6), 1'b1, 32'h1500, 2'b11);
        lookup(mk(3, 5, 3));
        expect_hit("R10", 32'h1500, 2'b11, 4'd6);
    endtask

    task automatic t_saturate;
        resolve(mk(1, 40, 4), 1'b1, 32'h4000, 2'b00);
        resolve(mk(1, 40, 4), 1'b1, 32'h4000, 2'b00);
        resolve(mk(1, 40, 4), 1'b1, 32'h4000, 2'b00);
        resolve(mk(1, 40, 4), 1'b1, 32'h4000, 2'b00);
        resolve(mk(1, 40, 4), 1'b0, 32'h4000, 2'b00);
        lookup(mk(1, 40, 0));
        expect_hit("R7", 32'h4000, 2'b00, 4'd4);
    endtask

    task automatic t_return;
        resolve(mk(2, 60, 9), 1'b0, 32'h5000, 2'b00);
        resolve(mk(2, 60, 9), 1'b0, 32'h5000, 2'b00);
        resolve(mk(2, 60, 9), 1'b0, 32'h5000, 2'b00);
        lookup(mk(2, 60, 0));
        expect_miss("R7", mk(2, 60, 0));
        resolve(mk(2, 60, 9), 1'b1, 32'h5000, 2'b01);
        lookup(mk(2, 60, 0));
        expect_hit("R6", 32'h5000, 2'b01, 4'd9);
    endtask

    task automatic t_replace;
        for (int t = 1; t <= 5; t++) begin
            resolve(mk(t, 20, 0), 1'b1, 32'(t * 256), 2'b11);
        end
        lookup(mk(1, 20, 0));
        expect_miss("R11", mk(1, 20, 0));
        lookup(mk(2, 20, 0));
        expect_hit("R11", 32'h200, 2'b11, 4'd0);
        lookup(mk(5, 20, 0));
        expect_hit("R11", 32'h500, 2'b11, 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latency;
        t_order;
        t_tag;
        t_cond_history;
        t_retarget;
        t_saturate;
        t_return;
        t_replace;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule